// File: doc/BRIEF.md
# Programmable Service-Request Priority Controller

This block merges four handshake status lines, called sources 1 to 4, into one active-low interrupt request. It also reports the index of the pending source that currently has the highest priority. One configuration byte sets three things. The first is which of eight fixed priority orders applies. The second is how the interrupt request and acknowledge pins are used. The third is whether source 1 or source 3 is taken over by a DMA request output.

Each order is built from three choices: swap the two sources within pair A (sources 1 and 2), swap the two within pair B (sources 3 and 4), and choose which pair ranks first. A source routed to DMA takes no part in interrupt arbitration. Its rising edge makes a one-clock DMA request pulse, but only if the service-request enable bit of its port is set.

Top module: `svc_prio_ctrl`

## Requirements
- R1: With the DMA field off, the priority field (cfg_wdata[6:4]) gives these orders, highest first, as source numbers: 000 → 1,2,3,4; 001 → 2,1,3,4; 010 → 1,2,4,3; 011 → 2,1,4,3.
- R2: Priority codes 100 to 111 rank pair B ahead of pair A: 100 → 3,4,1,2; 101 → 3,4,2,1; 110 → 4,3,1,2; 111 → 4,3,2,1.
- R3: The DMA field (cfg_wdata[1:0]) selects the DMA source. 00 and 01 mean no DMA. 10 routes source 1 (stat_in[0]) to DMA. 11 routes source 3 (stat_in[2]) to DMA.
- R4: A source routed to DMA is never reported as the winner and never causes irq_n to go low.
- R5: dma_req pulses only when the routed source's enable is set: porta_sreq_en for source 1, portb_sreq_en for source 3. With the DMA field at 00 or 01, dma_req never pulses.
- R6: The pin field (cfg_wdata[3:2]) sets the pins. 00: both are port pins. 01: request pin active, autovectored. 10: only the acknowledge pin active. 11: both pins active and vectored. req_pin_on is high for 01 and 11, ack_pin_on is high for 10 and 11, and vec_mode is high for 11 only.
- R7: dma_req is high for exactly one clock. It goes high in the cycle after the clock edge that first samples the routed status high after it was low. Holding the status high gives no further pulse.
- R8: irq_n is low exactly when req_pin_on is high and at least one source has its status set, its irq_en bit set, and is not routed to DMA. Sources with irq_en clear are ignored.
- R9: win_valid and win_idx (0 = source 1 … 3 = source 4) follow stat_in, irq_en and the priority field combinationally. They name the highest-ranked eligible pending source.
- R10: Reset sets the priority code to 000, the pin field to port pins and DMA to off, and holds dma_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 7 | Configuration: [6:4] priority, [3:2] pin mode, [1:0] DMA select |
| porta_sreq_en | input | 1 | Service-request enable for source 1 DMA |
| portb_sreq_en | input | 1 | Service-request enable for source 3 DMA |
| stat_in | input | 4 | Handshake status, bit n = source n+1 |
| irq_en | input | 4 | Per-source interrupt enable |
| irq_n | output | 1 | Interrupt request, active low |
| win_valid | output | 1 | An eligible source is pending |
| win_idx | output | 2 | Index of the highest-priority pending source |
| dma_req | output | 1 | One-clock DMA request pulse |
| req_pin_on | output | 1 | Request pin carries the interrupt function |
| ack_pin_on | output | 1 | Acknowledge pin carries the acknowledge function |
| vec_mode | output | 1 | Vectored interrupt mode |

## Verification
Every priority code is tried against all sixteen status patterns. Single-bit patterns show that each source is reachable. Multi-bit patterns tell apart orders that differ in only one swap. Masked patterns, with irq_en bits cleared or a source routed to DMA, separate true eligibility from raw status. The DMA pulse is driven with a clean rise, a held-high level, a second rise, a disabled port enable and a rise on the non-routed source, which separate edge detection from level sensing and show that routing is obeyed.

// File: rtl/svc_prio_pkg.sv
package svc_prio_pkg;
   localparam int NSRC   = 4;
   localparam int IDXW   = 2;
   localparam int PRIO_W = 3;

   typedef enum logic [1:0] {
      DMA_NONE0 = 2'b00,
      DMA_NONE1 = 2'b01,
      DMA_SRC1  = 2'b10,
      DMA_SRC3  = 2'b11
   } dma_sel_e;

   typedef enum logic [1:0] {
      PIN_PORT     = 2'b00,
      PIN_REQ_AUTO = 2'b01,
      PIN_ACK_ONLY = 2'b10,
      PIN_VECTORED = 2'b11
   } pin_mode_e;

   typedef struct packed {
      logic [PRIO_W-1:0] prio;
      pin_mode_e         pins;
      dma_sel_e          dma;
   } svc_cfg_t;

   localparam int CFG_W = $bits(svc_cfg_t);

   // Source index held in a given rank slot (0 = highest) under a priority code.
   function automatic logic [IDXW-1:0] slot_source(input logic [PRIO_W-1:0] code,
                                                   input logic [IDXW-1:0] slot);
      logic pair_b;
      logic member;
      pair_b = slot[1] ^ code[2];
      member = slot[0] ^ (pair_b ? code[1] : code[0]);
      return {pair_b, member};
   endfunction
endpackage

// File: rtl/svc_cfg_reg.sv
module svc_cfg_reg #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("svc_cfg_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/svc_prio_arb.sv
module svc_prio_arb
   import svc_prio_pkg::*;
#(
   parameter int N = NSRC,
   localparam int IW = $clog2(N)
) (
   input  logic [PRIO_W-1:0] prio,
   input  logic [N-1:0]      req,
   output logic              valid,
   output logic [IW-1:0]     idx
);
   generate
      if (N != 4 || IW != IDXW) begin : g_bad_count
         $error("svc_prio_arb: the pair-swap orders need exactly four sources");
      end
   endgenerate

   logic [N-1:0]  slot_req;
   logic [IW-1:0] slot_idx [N];

   genvar s;
   generate
      for (s = 0; s < N; s++) begin : g_slot
         assign slot_idx[s] = slot_source(prio, IW'(s));
         assign slot_req[s] = req[slot_idx[s]];
      end
   endgenerate

   // Scan from lowest rank to highest so the highest-ranked request wins.
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (slot_req[k]) begin
            valid = 1'b1;
            idx   = slot_idx[k];
         end
      end
   end
endmodule

// File: rtl/svc_dma_edge.sv
module svc_dma_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic stat,
   input  logic en,
   output logic pulse
);
   logic stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         stat_q <= stat;
         pulse  <= en & stat & ~stat_q;
      end
   end

   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   assert_pulse_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse) |-> $past(en) && $past(stat));
endmodule

// File: rtl/svc_prio_ctrl.sv
module svc_prio_ctrl
   import svc_prio_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             porta_sreq_en,
   input  logic             portb_sreq_en,
   input  logic [NSRC-1:0]  stat_in,
   input  logic [NSRC-1:0]  irq_en,
   output logic             irq_n,
   output logic             win_valid,
   output logic [IDXW-1:0]  win_idx,
   output logic             dma_req,
   output logic             req_pin_on,
   output logic             ack_pin_on,
   output logic             vec_mode
);
   logic [CFG_W-1:0] cfg_bits;
   svc_cfg_t         cfg;

   svc_cfg_reg #(.W(CFG_W)) u_cfg (
      .clk (clk),
      .rst_n (rst_n),
      .we  (cfg_we),
      .d   (cfg_wdata),
      .q   (cfg_bits)
   );
   assign cfg = svc_cfg_t'(cfg_bits);

   // DMA routing: the routed source leaves interrupt arbitration.
   logic [NSRC-1:0] dma_mask;
   logic            dma_stat;
   logic            dma_en;

   always_comb begin
      dma_mask = '0;
      dma_stat = 1'b0;
      dma_en   = 1'b0;
      unique case (cfg.dma)
         DMA_SRC1: begin
            dma_mask[0] = 1'b1;
            dma_stat    = stat_in[0];
            dma_en      = porta_sreq_en;
         end
         DMA_SRC3: begin
            dma_mask[2] = 1'b1;
            dma_stat    = stat_in[2];
            dma_en      = portb_sreq_en;
         end
         default: ;
      endcase
   end

   logic [NSRC-1:0] eligible;
   assign eligible = stat_in & irq_en & ~dma_mask;

   svc_prio_arb #(.N(NSRC)) u_arb (
      .prio  (cfg.prio),
      .req   (eligible),
      .valid (win_valid),
      .idx   (win_idx)
   );

   svc_dma_edge u_dma (
      .clk   (clk),
      .rst_n (rst_n),
      .stat  (dma_stat),
      .en    (dma_en),
      .pulse (dma_req)
   );

   // Pin function decode.
   assign req_pin_on = (cfg.pins == PIN_REQ_AUTO) || (cfg.pins == PIN_VECTORED);
   assign ack_pin_on = (cfg.pins == PIN_ACK_ONLY) || (cfg.pins == PIN_VECTORED);
   assign vec_mode   = (cfg.pins == PIN_VECTORED);
   assign irq_n      = ~(req_pin_on & win_valid);

   assert_dma_src1_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.dma == DMA_SRC1 && win_valid) |-> win_idx != 2'd0);

   assert_dma_src3_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.dma == DMA_SRC3 && win_valid) |-> win_idx != 2'd2);

   assert_win_is_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> stat_in[win_idx] && irq_en[win_idx]);

   assert_no_win_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_in & irq_en) == '0 |-> irq_n && !win_valid);

   assert_dma_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.dma[1] == 1'b0 && $past(cfg.dma[1] == 1'b0)) |=> !dma_req);
endmodule

// File: tb/svc_prio_ctrl_test.sv
module svc_prio_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_we;
   logic [6:0] cfg_wdata;
   logic       porta_sreq_en, portb_sreq_en;
   logic [3:0] stat_in, irq_en;
   logic       irq_n, win_valid, dma_req, req_pin_on, ack_pin_on, vec_mode;
   logic [1:0] win_idx;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   svc_prio_ctrl uut (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
      .porta_sreq_en (porta_sreq_en), .portb_sreq_en (portb_sreq_en),
      .stat_in (stat_in), .irq_en (irq_en), .irq_n (irq_n),
      .win_valid (win_valid), .win_idx (win_idx), .dma_req (dma_req),
      .req_pin_on (req_pin_on), .ack_pin_on (ack_pin_on), .vec_mode (vec_mode)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Ranked source list per code, highest first, taken from R1 and R2.
   function automatic int ranked(input int code, input int slot);
      int tbl [8][4] = '{'{0,1,2,3}, '{1,0,2,3}, '{0,1,3,2}, '{1,0,3,2},
                         '{2,3,0,1}, '{2,3,1,0}, '{3,2,0,1}, '{3,2,1,0}};
      return tbl[code][slot];
   endfunction

   function automatic int expect_win(input int code, input logic [3:0] elig);
      for (int s = 0; s < 4; s++)
         if (elig[ranked(code, s)]) return ranked(code, s);
      return -1;
   endfunction

   task automatic write_cfg(input int prio, input int pins, input int dma);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = {3'(prio), 2'(pins), 2'(dma)};
      @(negedge clk);
      cfg_we    = 1'b0;
      #1;
   endtask

   task automatic set_stat(input logic [3:0] v);
      @(negedge clk);
      stat_in = v;
      #1;
   endtask

   task automatic check_win(input string req, input int exp);
      check(win_valid == (exp >= 0), req, int'(win_valid), int'(exp >= 0));
      if (exp >= 0) check(int'(win_idx) == exp, req, int'(win_idx), exp);
   endtask

   task automatic test_reset();
      check(dma_req == 1'b0, "R10 dma_req in reset", int'(dma_req), 0);
      check(req_pin_on == 1'b0 && ack_pin_on == 1'b0 && vec_mode == 1'b0,
            "R10 pins in reset", int'({req_pin_on, ack_pin_on, vec_mode}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      stat_in = 4'b1111;
      #1;
      check_win("R10 prio 000 after reset", 0);
      check(irq_n == 1'b1, "R10 port pins keep irq_n high", int'(irq_n), 1);
      stat_in = 4'b0000;
   endtask

   task automatic test_orders();
      for (int code = 0; code < 8; code++) begin
         write_cfg(code, 3, 0);
         for (int p = 0; p < 16; p++) begin
            stat_in = 4'(p);
            #1;
            check_win(code < 4 ? "R1 order" : "R2 order", expect_win(code, 4'(p)));
            check(irq_n == (p == 0), "R8 irq_n level", int'(irq_n), int'(p == 0));
         end
      end
      stat_in = 4'b0000;
   endtask

   task automatic test_dma_mask();
      write_cfg(0, 3, 2);
      set_stat(4'b0001);
      check_win("R4 source 1 routed to DMA", -1);
      check(irq_n == 1'b1, "R4 irq_n with source 1 on DMA", int'(irq_n), 1);
      set_stat(4'b0011);
      check_win("R3 source 2 still arbitrates", 1);
      write_cfg(0, 3, 3);
      set_stat(4'b0100);
      check_win("R4 source 3 routed to DMA", -1);
      check(irq_n == 1'b1, "R4 irq_n with source 3 on DMA", int'(irq_n), 1);
      set_stat(4'b0101);
      check_win("R3 source 1 back in arbitration", 0);
      write_cfg(0, 3, 1);
      set_stat(4'b0101);
      check_win("R3 code 01 means no DMA", 0);
      set_stat(4'b0000);
   endtask

   task automatic test_dma_pulse();
      porta_sreq_en = 1'b1;
      portb_sreq_en = 1'b1;
      write_cfg(0, 3, 2);
      set_stat(4'b0001);
      @(posedge clk); #1;
      check(dma_req == 1'b1, "R7 pulse after rise", int'(dma_req), 1);
      @(posedge clk); #1;
      check(dma_req == 1'b0, "R7 pulse lasts one clock", int'(dma_req), 0);
      @(posedge clk); #1;
      check(dma_req == 1'b0, "R7 held high gives no pulse", int'(dma_req), 0);
      set_stat(4'b0000);
      set_stat(4'b0001);
      @(posedge clk); #1;
      check(dma_req == 1'b1, "R7 second rise pulses", int'(dma_req), 1);
      set_stat(4'b0000);
      write_cfg(0, 3, 3);
      set_stat(4'b0100);
      @(posedge clk); #1;
      check(dma_req == 1'b1, "R3 source 3 pulse", int'(dma_req), 1);
      set_stat(4'b0000);
      set_stat(4'b0001);
      @(posedge clk); #1;
      check(dma_req == 1'b0, "R3 source 1 ignored in source 3 mode", int'(dma_req), 0);
      set_stat(4'b0000);
   endtask

   task automatic test_dma_enable();
      porta_sreq_en = 1'b0;
      portb_sreq_en = 1'b1;
      write_cfg(0, 3, 2);
      set_stat(4'b0001);
      @(posedge clk); #1;
      check(dma_req == 1'b0, "R5 port A enable clear", int'(dma_req), 0);
      set_stat(4'b0000);
      porta_sreq_en = 1'b1;
      write_cfg(0, 3, 0);
      set_stat(4'b0101);
      @(posedge clk); #1;
      check(dma_req == 1'b0, "R5 no pulse with DMA off", int'(dma_req), 0);
      set_stat(4'b0000);
   endtask

   task automatic test_pin_modes();
      stat_in = 4'b1000;
      for (int m = 0; m < 4; m++) begin
         write_cfg(0, m, 0);
         check(req_pin_on == (m == 1 || m == 3), "R6 req_pin_on", int'(req_pin_on),
               int'(m == 1 || m == 3));
         check(ack_pin_on == (m >= 2), "R6 ack_pin_on", int'(ack_pin_on), int'(m >= 2));
         check(vec_mode == (m == 3), "R6 vec_mode", int'(vec_mode), int'(m == 3));
         check(irq_n == !(m == 1 || m == 3), "R8 irq_n follows request pin",
               int'(irq_n), int'(!(m == 1 || m == 3)));
      end
      stat_in = 4'b0000;
   endtask

   task automatic test_irq_enable();
      write_cfg(0, 1, 0);
      irq_en = 4'b0010;
      set_stat(4'b0101);
      check_win("R8 disabled sources ignored", -1);
      check(irq_n == 1'b1, "R8 irq_n with only disabled pending", int'(irq_n), 1);
      set_stat(4'b0111);
      check_win("R9 enabled source wins", 1);
      check(irq_n == 1'b0, "R8 irq_n low for enabled source", int'(irq_n), 0);
      irq_en = 4'b1111;
      #1;
      check_win("R9 follows irq_en combinationally", 0);
      set_stat(4'b0000);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_we = 1'b0;
      cfg_wdata = '0;
      porta_sreq_en = 1'b0;
      portb_sreq_en = 1'b0;
      stat_in = 4'b0000;
      irq_en = 4'b1111;
      repeat (3) @(posedge clk);
      #1;
      test_reset();
      test_orders();
      test_dma_mask();
      test_dma_pulse();
      test_dma_enable();
      test_pin_modes();
      test_irq_enable();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule